// File: doc/BRIEF.md
# Dual-Channel IDE PIO Cycle Generator

This block turns local-bus I/O requests into drive-side cycles on two IDE channels. It decodes the 10-bit I/O address into one of four chip selects: command block or control block, on channel 0 or channel 1. A 16-bit access to a channel's data port is timed inside the block. The strobe width and the total cycle length are counted in local-clock periods and taken from a table. That table is indexed by a clock-speed pin and by a PIO mode code, so the drive sees the same nanosecond timing whether the local clock runs with a 30 ns or a 20 ns period.

Every other decoded access is an ISA-slaved cycle. This covers all 8-bit accesses, control-block accesses and 16-bit accesses to non-data registers. In such a cycle the block raises the chip select and copies the external ISA read and write commands onto the drive strobes. In both kinds of cycle a one-clock `done` pulse in the last clock of the cycle tells the requester that the transfer is finished. The requester holds `req_valid` high until it sees `done`.

Top module: `ide_pio_cycle_gen`

## Requirements
- R1: Channel 0 command-block select (`cs_cmd[0]`) is driven for addresses 0x1F0–0x1F7, and its control-block select (`cs_ctl[0]`) is driven for address 0x3F6 only; at most one select is high at any time.
- R2: Channel 1 command-block select (`cs_cmd[1]`) is driven for addresses 0x170–0x177, and its control-block select (`cs_ctl[1]`) is driven for address 0x376 only.
- R3: A request to any other address is ignored: no select, no strobe and no `done`, even while ISA commands toggle.
- R4: A timed cycle of length C asserts its select in the clock after the request is accepted and keeps it for exactly C clocks. The strobe (`drv_wr` for a write, `drv_rd` for a read) starts one clock after the select, the other strobe stays low, and `done` is high in the last of the C clocks, with both strobes already low.
- R5: With `ext_en`=0 and `speed_fast`=0 (write/read/cycle clocks), `base_code` 00 gives 6/7/22, 01 gives 6/7/19, 10 gives 5/6/13 and 11 gives 4/5/8.
- R6: With `ext_en`=0 and `speed_fast`=1, `base_code` 00 gives 9/10/33, 01 gives 9/10/29, 10 gives 7/8/20 and 11 gives 5/6/12.
- R7: With `ext_en`=1, `ext_code` 00/01/10/11 gives 4/5/8, 3/4/6, 3/4/6, 3/4/6 at `speed_fast`=0 and 5/6/12, 4/5/9, 4/5/7, 4/5/7 at `speed_fast`=1.
- R8: Speed and mode pins are sampled when a cycle is accepted. Changing them during a cycle does not alter that cycle, and the next cycle uses the new values.
- R9: In an ISA-slaved cycle the select is high from the clock after acceptance. `drv_rd`/`drv_wr` copy `isa_rd`/`isa_wr` one clock late. Once a command has been seen and both commands are low again, `done` is high for one clock with the select still held, and the select then drops.
- R10: After `done`, all selects are low for at least one clock. A request still held high is accepted in the clock after that gap.
- R11: During and immediately after reset, all selects, strobes and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local-bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until `done` |
| req_addr | input | 10 | I/O address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit |
| isa_rd | input | 1 | External ISA read command, active high |
| isa_wr | input | 1 | External ISA write command, active high |
| speed_fast | input | 1 | 0 = 30 ns clock period, 1 = 20 ns |
| ext_en | input | 1 | 1 = use `ext_code` (modes 2–4), 0 = use `base_code` |
| base_code | input | 2 | Base mode code (modes 0, 0+, 1, 2) |
| ext_code | input | 2 | Extended mode code (modes 2, 3, 4, 4) |
| cs_cmd | output | 2 | Command-block select per channel |
| cs_ctl | output | 2 | Control-block select per channel |
| drv_rd | output | 1 | Drive read strobe |
| drv_wr | output | 1 | Drive write strobe |
| done | output | 1 | Last clock of the current cycle |

## Verification
Every output is registered. After the request edge, the select is due one clock later, a timed strobe two clocks later, and `done` C clocks later. In the ISA path the strobe lags the ISA command by one clock and `done` follows one clock after the command falls. The bench drives inputs and samples outputs on falling edges and indexes each sample from the first falling edge after acceptance. It then compares the recorded start index, strobe width, select length and `done` index with the table values.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

    localparam int NCH    = 2;
    localparam int ADDR_W = 10;
    localparam int CNT_W  = 6;
    localparam int NMODE  = 6;

    typedef logic [CNT_W-1:0] tcnt_t;

    typedef enum logic [2:0] {
        PM_0, PM_0P, PM_1, PM_2, PM_3, PM_4
    } pio_mode_e;

    typedef struct packed {
        tcnt_t wr_len;
        tcnt_t rd_len;
        tcnt_t cyc_len;
    } pio_timing_t;

    typedef enum logic [1:0] {
        ST_IDLE, ST_TIMED, ST_ISA, ST_ISA_END
    } seq_state_e;

    typedef struct packed {
        seq_state_e       st;
        tcnt_t            cnt;
        tcnt_t            plen;
        tcnt_t            clen;
        logic             wr;
        logic             seen;
        logic [NCH-1:0]   cs_cmd;
        logic [NCH-1:0]   cs_ctl;
        logic             drv_rd;
        logic             drv_wr;
        logic             done;
    } seq_t;

    // Minimum strobe width per mode in ns (16-bit data transfers).
    function automatic int strobe_ns(pio_mode_e m);
        case (m)
            PM_0, PM_0P: return 165;
            PM_1:        return 125;
            PM_2:        return 100;
            PM_3:        return 80;
            default:     return 70;
        endcase
    endfunction

    // Cycle length per mode in ns, each at or above the PIO minimum.
    function automatic int cycle_ns(pio_mode_e m);
        case (m)
            PM_0:    return 660;
            PM_0P:   return 570;
            PM_1:    return 383;
            PM_2:    return 240;
            PM_3:    return 180;
            default: return 120;
        endcase
    endfunction

    function automatic int ceil_div(int a, int b);
        return (a + b - 1) / b;
    endfunction

    // Read strobe gets one extra clock; cycle must fit setup + strobe + hold.
    function automatic pio_timing_t derive_timing(pio_mode_e m, int period_ns);
        pio_timing_t t;
        int w;
        int r;
        int c;
        w = ceil_div(strobe_ns(m), period_ns);
        r = w + 1;
        c = ceil_div(cycle_ns(m), period_ns);
        if (c < r + 2) c = r + 2;
        t.wr_len  = tcnt_t'(w);
        t.rd_len  = tcnt_t'(r);
        t.cyc_len = tcnt_t'(c);
        return t;
    endfunction

    function automatic logic [ADDR_W-1:0] cmd_base(int ch);
        return (ch == 0) ? ADDR_W'('h1F0) : ADDR_W'('h170);
    endfunction

    function automatic logic [ADDR_W-1:0] ctl_addr(int ch);
        return (ch == 0) ? ADDR_W'('h3F6) : ADDR_W'('h376);
    endfunction

endpackage

// File: rtl/ide_addr_decode.sv
module ide_addr_decode
    import ide_pio_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wide_i,
    output logic [NCH-1:0]    cmd_hit_o,
    output logic [NCH-1:0]    ctl_hit_o,
    output logic              timed_o
);
    localparam int SEL_W = 3;

    logic [NCH-1:0] port_hit;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        localparam logic [ADDR_W-1:0] CMD_A = cmd_base(g);
        localparam logic [ADDR_W-1:0] CTL_A = ctl_addr(g);
        assign cmd_hit_o[g] = (addr_i[ADDR_W-1:SEL_W] == CMD_A[ADDR_W-1:SEL_W]);
        assign ctl_hit_o[g] = (addr_i == CTL_A);
        assign port_hit[g]  = (addr_i == CMD_A);
    end

    assign timed_o = wide_i && (|port_hit);

endmodule

// File: rtl/ide_pio_timing.sv
module ide_pio_timing
    import ide_pio_pkg::*;
#(
    parameter int SLOW_NS = 30,
    parameter int FAST_NS = 20
) (
    input  logic        speed_fast_i,
    input  logic        ext_en_i,
    input  logic [1:0]  base_code_i,
    input  logic [1:0]  ext_code_i,
    output pio_timing_t timing_o
);
    pio_mode_e   mode;
    pio_timing_t tbl_slow [NMODE];
    pio_timing_t tbl_fast [NMODE];

    for (genvar g = 0; g < NMODE; g++) begin : g_tbl
        assign tbl_slow[g] = derive_timing(pio_mode_e'(g), SLOW_NS);
        assign tbl_fast[g] = derive_timing(pio_mode_e'(g), FAST_NS);
    end

    always_comb begin
        if (ext_en_i) begin
            case (ext_code_i)
                2'b00:   mode = PM_2;
                2'b01:   mode = PM_3;
                default: mode = PM_4;
            endcase
        end else begin
            case (base_code_i)
                2'b00:   mode = PM_0;
                2'b01:   mode = PM_0P;
                2'b10:   mode = PM_1;
                default: mode = PM_2;
            endcase
        end
    end

    assign timing_o = speed_fast_i ? tbl_fast[mode] : tbl_slow[mode];

    // R4: every entry leaves room for select setup and hold around the strobe
    always_comb begin
        a_r4_entry_fits: assert (timing_o.cyc_len >= timing_o.rd_len + tcnt_t'(2))
            else $error("timing entry too short for setup and hold");
    end

endmodule

// File: rtl/ide_pio_seq.sv
module ide_pio_seq
    import ide_pio_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid_i,
    input  logic           req_write_i,
    input  logic [NCH-1:0] cmd_hit_i,
    input  logic [NCH-1:0] ctl_hit_i,
    input  logic           timed_i,
    input  pio_timing_t    timing_i,
    input  logic           isa_rd_i,
    input  logic           isa_wr_i,
    output logic [NCH-1:0] cs_cmd_o,
    output logic [NCH-1:0] cs_ctl_o,
    output logic           drv_rd_o,
    output logic           drv_wr_o,
    output logic           done_o
);
    seq_t  q;
    seq_t  d;
    tcnt_t next_cnt;
    logic  strobe_on;
    logic  hit;

    assign hit = (|cmd_hit_i) || (|ctl_hit_i);

    always_comb begin
        d         = q;
        next_cnt  = q.cnt + tcnt_t'(1);
        strobe_on = 1'b0;
        case (q.st)
            ST_IDLE: begin
                d.done   = 1'b0;
                d.drv_rd = 1'b0;
                d.drv_wr = 1'b0;
                if (req_valid_i && hit) begin
                    d.cs_cmd = cmd_hit_i;
                    d.cs_ctl = ctl_hit_i;
                    d.cnt    = '0;
                    d.wr     = req_write_i;
                    d.seen   = 1'b0;
                    d.plen   = req_write_i ? timing_i.wr_len : timing_i.rd_len;
                    d.clen   = timing_i.cyc_len;
                    d.st     = timed_i ? ST_TIMED : ST_ISA;
                end
            end
            ST_TIMED: begin
                if (q.cnt == q.clen - tcnt_t'(1)) begin
                    d.st     = ST_IDLE;
                    d.cs_cmd = '0;
                    d.cs_ctl = '0;
                    d.done   = 1'b0;
                    d.drv_rd = 1'b0;
                    d.drv_wr = 1'b0;
                end else begin
                    d.cnt     = next_cnt;
                    strobe_on = (next_cnt <= q.plen);
                    d.drv_wr  = strobe_on && q.wr;
                    d.drv_rd  = strobe_on && !q.wr;
                    d.done    = (next_cnt == q.clen - tcnt_t'(1));
                end
            end
            ST_ISA: begin
                d.drv_rd = isa_rd_i;
                d.drv_wr = isa_wr_i;
                if (isa_rd_i || isa_wr_i) begin
                    d.seen = 1'b1;
                end else if (q.seen) begin
                    d.st   = ST_ISA_END;
                    d.done = 1'b1;
                end
            end
            default: begin
                d.st     = ST_IDLE;
                d.cs_cmd = '0;
                d.cs_ctl = '0;
                d.done   = 1'b0;
                d.drv_rd = 1'b0;
                d.drv_wr = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cs_cmd_o = q.cs_cmd;
    assign cs_ctl_o = q.cs_ctl;
    assign drv_rd_o = q.drv_rd;
    assign drv_wr_o = q.drv_wr;
    assign done_o   = q.done;

    // R1: never more than one select
    a_r1_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q.cs_cmd, q.cs_ctl}));

    // R4: a strobe only inside a select window
    a_r4_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (q.drv_rd || q.drv_wr) |-> (|{q.cs_cmd, q.cs_ctl}));

    // R4: select set up at least one clock before a strobe rises
    a_r4_cs_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.drv_rd || q.drv_wr) |-> $past(|{q.cs_cmd, q.cs_ctl}));

    // R4: done arrives with the select still held and strobes released
    a_r4_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> ((|{q.cs_cmd, q.cs_ctl}) && !q.drv_rd && !q.drv_wr));

    // R4: the cycle counter stays below the latched length
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_TIMED) |-> (q.cnt < q.clen));

    // R8: latched cycle length stays fixed through a timed cycle
    a_r8_len_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_TIMED) && $past(q.st == ST_TIMED)) |-> $stable(q.clen));

    // R9: ISA-slaved strobes copy the commands one clock late
    a_r9_isa_follow: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_ISA) && $past(q.st == ST_ISA))
            |-> ((q.drv_rd == $past(isa_rd_i)) && (q.drv_wr == $past(isa_wr_i))));

    // R10: selects drop in the clock after done
    a_r10_gap_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> ((q.cs_cmd == '0) && (q.cs_ctl == '0)));

endmodule

// File: rtl/ide_pio_cycle_gen.sv
module ide_pio_cycle_gen
    import ide_pio_pkg::*;
#(
    parameter int SLOW_NS = 30,
    parameter int FAST_NS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic              isa_rd,
    input  logic              isa_wr,
    input  logic              speed_fast,
    input  logic              ext_en,
    input  logic [1:0]        base_code,
    input  logic [1:0]        ext_code,
    output logic [NCH-1:0]    cs_cmd,
    output logic [NCH-1:0]    cs_ctl,
    output logic              drv_rd,
    output logic              drv_wr,
    output logic              done
);
    logic [NCH-1:0] cmd_hit;
    logic [NCH-1:0] ctl_hit;
    logic           timed;
    pio_timing_t    timing;

    ide_addr_decode u_decode (
        .addr_i    (req_addr),
        .wide_i    (req_wide),
        .cmd_hit_o (cmd_hit),
        .ctl_hit_o (ctl_hit),
        .timed_o   (timed)
    );

    ide_pio_timing #(
        .SLOW_NS (SLOW_NS),
        .FAST_NS (FAST_NS)
    ) u_timing (
        .speed_fast_i (speed_fast),
        .ext_en_i     (ext_en),
        .base_code_i  (base_code),
        .ext_code_i   (ext_code),
        .timing_o     (timing)
    );

    ide_pio_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .req_write_i (req_write),
        .cmd_hit_i   (cmd_hit),
        .ctl_hit_i   (ctl_hit),
        .timed_i     (timed),
        .timing_i    (timing),
        .isa_rd_i    (isa_rd),
        .isa_wr_i    (isa_wr),
        .cs_cmd_o    (cs_cmd),
        .cs_ctl_o    (cs_ctl),
        .drv_rd_o    (drv_rd),
        .drv_wr_o    (drv_wr),
        .done_o      (done)
    );

endmodule

// File: tb/tb_ide_pio_cycle_gen.sv
module tb_ide_pio_cycle_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [9:0] req_addr = '0;
    logic       req_write = 1'b0;
    logic       req_wide = 1'b0;
    logic       isa_rd = 1'b0;
    logic       isa_wr = 1'b0;
    logic       speed_fast = 1'b0;
    logic       ext_en = 1'b0;
    logic [1:0] base_code = '0;
    logic [1:0] ext_code = '0;
    logic [1:0] cs_cmd;
    logic [1:0] cs_ctl;
    logic       drv_rd;
    logic       drv_wr;
    logic       done;

    int total = 0;
    int bad = 0;

    // select masks: {cs_cmd[1], cs_cmd[0], cs_ctl[1], cs_ctl[0]}
    localparam logic [3:0] M_CMD0 = 4'b0100;
    localparam logic [3:0] M_CMD1 = 4'b1000;
    localparam logic [3:0] M_CTL0 = 4'b0001;
    localparam logic [3:0] M_CTL1 = 4'b0010;

    int          m_cs_len, m_strb_first, m_strb_len, m_done_idx, m_done_cnt, m_wrong, m_bad_cs;
    logic [63:0] m_hist;

    always #4 clk = ~clk;

    ide_pio_cycle_gen dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_wide(req_wide), .isa_rd(isa_rd), .isa_wr(isa_wr),
        .speed_fast(speed_fast), .ext_en(ext_en), .base_code(base_code), .ext_code(ext_code),
        .cs_cmd(cs_cmd), .cs_ctl(cs_ctl), .drv_rd(drv_rd), .drv_wr(drv_wr), .done(done)
    );

    task automatic chk(input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic set_pins(input logic sp, input logic ext, input logic [1:0] code);
        @(negedge clk);
        speed_fast = sp;
        ext_en     = ext;
        base_code  = ext ? 2'b00 : code;
        ext_code   = ext ? code : 2'b00;
    endtask

    // Issue one request and record 48 falling-edge samples indexed from acceptance.
    task automatic run_txn(input logic [9:0] addr, input logic wide, input logic wr,
                           input logic [3:0] mask, input int isa_len,
                           input int chg_at, input int drop_at);
        logic [3:0] cur;
        logic       stb, oth;
        @(negedge clk);
        req_addr  = addr;
        req_wide  = wide;
        req_write = wr;
        req_valid = 1'b1;
        m_strb_first = -1; m_strb_len = 0; m_done_idx = -1; m_done_cnt = 0;
        m_wrong = 0; m_bad_cs = 0; m_hist = '0;
        for (int i = 0; i < 48; i++) begin
            @(negedge clk);
            cur = {cs_cmd, cs_ctl};
            m_hist[i] = (cur == mask) && (mask != 4'b0000);
            if (cur != 4'b0000 && cur != mask) m_bad_cs++;
            stb = wr ? drv_wr : drv_rd;
            oth = wr ? drv_rd : drv_wr;
            if (oth) m_wrong++;
            if (stb) begin
                if (m_strb_first < 0) m_strb_first = i;
                m_strb_len++;
            end
            if (done) begin
                if (m_done_idx < 0) m_done_idx = i;
                m_done_cnt++;
            end
            if ((drop_at < 0) ? (done == 1'b1) : (i == drop_at)) req_valid = 1'b0;
            if (isa_len > 0) begin
                if (i == 1)           begin isa_rd = !wr; isa_wr = wr; end
                if (i == 1 + isa_len) begin isa_rd = 1'b0; isa_wr = 1'b0; end
            end
            if (i == chg_at) begin
                speed_fast = 1'b1; ext_en = 1'b1; ext_code = 2'b10; base_code = 2'b11;
            end
        end
        req_valid = 1'b0;
        m_cs_len = 0;
        for (int i = 0; i < 48; i++) begin
            if (!m_hist[i]) break;
            m_cs_len++;
        end
    endtask

    task automatic t_timed(input string tag, input logic [9:0] addr, input logic wr,
                           input logic [3:0] mask, input logic sp, input logic ext,
                           input logic [1:0] code, input int ew, input int er, input int ec);
        set_pins(sp, ext, code);
        run_txn(addr, 1'b1, wr, mask, 0, -1, -1);
        chk($sformatf("R4 strobe start %s", tag), m_strb_first, 1);
        chk($sformatf("%s strobe width", tag), m_strb_len, wr ? ew : er);
        chk($sformatf("%s cycle length", tag), m_cs_len, ec);
        chk($sformatf("R4 done index %s", tag), m_done_idx, ec - 1);
        chk($sformatf("R4 other strobe %s", tag), m_wrong, 0);
        chk($sformatf("R1 wrong select %s", tag), m_bad_cs, 0);
    endtask

    task automatic t_isa(input string tag, input logic [9:0] addr, input logic wide,
                         input logic wr, input logic [3:0] mask, input int len);
        run_txn(addr, wide, wr, mask, len, -1, -1);
        chk($sformatf("R9 strobe start %s", tag), m_strb_first, 2);
        chk($sformatf("R9 strobe width %s", tag), m_strb_len, len);
        chk($sformatf("R9 done index %s", tag), m_done_idx, 2 + len);
        chk($sformatf("R9 select length %s", tag), m_cs_len, 3 + len);
        chk($sformatf("%s select decode", tag), m_bad_cs, 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 outputs in reset", int'({cs_cmd, cs_ctl, drv_rd, drv_wr, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 outputs after reset", int'({cs_cmd, cs_ctl, drv_rd, drv_wr, done}), 0);
    endtask

    task automatic t_ignored(input logic [9:0] addr);
        run_txn(addr, 1'b1, 1'b0, 4'b0000, 3, -1, 8);
        chk($sformatf("R3 select for %0h", addr), m_bad_cs, 0);
        chk($sformatf("R3 strobe for %0h", addr), m_strb_len, 0);
        chk($sformatf("R3 done for %0h", addr), m_done_cnt, 0);
    endtask

    task automatic t_param_latch;
        set_pins(1'b0, 1'b0, 2'b00);
        run_txn(10'h1F0, 1'b1, 1'b0, M_CMD0, 0, 2, -1);
        chk("R8 strobe kept after pin change", m_strb_len, 7);
        chk("R8 cycle kept after pin change", m_cs_len, 22);
        run_txn(10'h1F0, 1'b1, 1'b0, M_CMD0, 0, -1, -1);
        chk("R8 next cycle strobe uses new pins", m_strb_len, 5);
        chk("R8 next cycle length uses new pins", m_cs_len, 7);
    endtask

    task automatic t_back_to_back;
        set_pins(1'b0, 1'b0, 2'b11);
        run_txn(10'h170, 1'b1, 1'b0, M_CMD1, 0, -1, 9);
        chk("R10 first cycle length", m_cs_len, 8);
        chk("R10 gap after done", int'(m_hist[8]), 0);
        chk("R10 held request restarts", int'(m_hist[9]), 1);
        chk("R10 two done pulses", m_done_cnt, 2);
        chk("R10 second done index", m_done_idx + 9, 16);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        // R5 base table at the slow clock
        t_timed("R5 c00 rd", 10'h1F0, 1'b0, M_CMD0, 1'b0, 1'b0, 2'b00, 6, 7, 22);
        t_timed("R5 c00 wr", 10'h1F0, 1'b1, M_CMD0, 1'b0, 1'b0, 2'b00, 6, 7, 22);
        t_timed("R5 c01 rd", 10'h1F0, 1'b0, M_CMD0, 1'b0, 1'b0, 2'b01, 6, 7, 19);
        t_timed("R5 c10 wr", 10'h170, 1'b1, M_CMD1, 1'b0, 1'b0, 2'b10, 5, 6, 13);
        t_timed("R5 c11 rd", 10'h170, 1'b0, M_CMD1, 1'b0, 1'b0, 2'b11, 4, 5, 8);
        // R6 base table at the fast clock
        t_timed("R6 c00 wr", 10'h1F0, 1'b1, M_CMD0, 1'b1, 1'b0, 2'b00, 9, 10, 33);
        t_timed("R6 c01 rd", 10'h170, 1'b0, M_CMD1, 1'b1, 1'b0, 2'b01, 9, 10, 29);
        t_timed("R6 c10 rd", 10'h1F0, 1'b0, M_CMD0, 1'b1, 1'b0, 2'b10, 7, 8, 20);
        t_timed("R6 c11 wr", 10'h170, 1'b1, M_CMD1, 1'b1, 1'b0, 2'b11, 5, 6, 12);
        // R7 extended table
        t_timed("R7 s0 e00 rd", 10'h1F0, 1'b0, M_CMD0, 1'b0, 1'b1, 2'b00, 4, 5, 8);
        t_timed("R7 s0 e01 wr", 10'h1F0, 1'b1, M_CMD0, 1'b0, 1'b1, 2'b01, 3, 4, 6);
        t_timed("R7 s0 e10 rd", 10'h170, 1'b0, M_CMD1, 1'b0, 1'b1, 2'b10, 3, 4, 6);
        t_timed("R7 s0 e11 wr", 10'h170, 1'b1, M_CMD1, 1'b0, 1'b1, 2'b11, 3, 4, 6);
        t_timed("R7 s1 e00 rd", 10'h1F0, 1'b0, M_CMD0, 1'b1, 1'b1, 2'b00, 5, 6, 12);
        t_timed("R7 s1 e01 rd", 10'h170, 1'b0, M_CMD1, 1'b1, 1'b1, 2'b01, 4, 5, 9);
        t_timed("R7 s1 e10 wr", 10'h1F0, 1'b1, M_CMD0, 1'b1, 1'b1, 2'b10, 4, 5, 7);
        t_timed("R7 s1 e11 rd", 10'h170, 1'b0, M_CMD1, 1'b1, 1'b1, 2'b11, 4, 5, 7);
        // R8 pins sampled at acceptance
        t_param_latch();
        // R1, R2 and R9: ISA-slaved cycles on every select
        set_pins(1'b0, 1'b0, 2'b00);
        t_isa("R1 cmd 1F7", 10'h1F7, 1'b0, 1'b0, M_CMD0, 3);
        t_isa("R1 ctl 3F6", 10'h3F6, 1'b0, 1'b1, M_CTL0, 2);
        t_isa("R2 cmd 176", 10'h176, 1'b0, 1'b0, M_CMD1, 4);
        t_isa("R2 ctl 376", 10'h376, 1'b0, 1'b1, M_CTL1, 1);
        t_isa("R1 byte data port", 10'h1F0, 1'b0, 1'b1, M_CMD0, 2);
        t_isa("R2 wide non-data 172", 10'h172, 1'b1, 1'b0, M_CMD1, 5);
        // R3 unmatched addresses
        t_ignored(10'h1F8);
        t_ignored(10'h16F);
        t_ignored(10'h3F7);
        t_ignored(10'h377);
        // R10 back-to-back
        t_back_to_back();
        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule